// File: doc/BRIEF.md
# Strided DMA Address Generator

This block produces the address pairs for a single DMA transfer, one pair per beat. One address is on the tightly coupled (internal) side and the other is on the external side. A start pulse captures the transfer parameters:

- the two base addresses,
- a byte length,
- an unsigned 12-bit byte stride,
- a 2-bit transaction size.

The parameters are checked in the same cycle. A bad set is refused with a one-cycle error pulse, and no beat is issued.

A good set starts the transfer. Beats are then offered on a valid/ready handshake. The internal address always moves forward by the transaction size. The external address moves forward by the stride. A stride of zero keeps the external address fixed, which suits a FIFO-like location.

The final beat is flagged as last. A one-cycle done pulse follows it. A stop request ends the transfer once the beat currently on offer has been accepted.

Top module: `strided_dma_agen`

## Requirements
- R1: After reset, beat_valid, beat_last, done and bad_param are all low.
- R2: xsize selects the beat size. The encoding is 00 = 1 byte, 01 = 2, 10 = 4 and 11 = 8 bytes. Beat k (counting from 0) carries internal address int_base + k*size, modulo 2^AW. Beat 0 appears on the cycle after the accepted start.
- R3: Beat k carries external address ext_base + k*stride, modulo 2^AW. The stride is an unsigned 12-bit byte count and does not depend on the size.
- R4: With a stride of 0, every beat of the transfer carries ext_base as its external address.
- R5: The cycle after start, bad_param is high for exactly one cycle and no beat is offered if any of the following is not a multiple of the beat size: the stride, int_base, ext_base or the length.
- R6: A transfer has length/size beats. With a length of 0 and no parameter error, done is high on the cycle after start and no beat is offered.
- R7: Addresses move on only when beat_valid and beat_ready are both high on a clock edge. Once beat_valid is high, it stays high with stable addresses until the beat is accepted.
- R8: beat_last is high only on the final beat. done is high for exactly one cycle, on the cycle after the final beat is accepted, and beat_valid is low on that cycle.
- R9: A stop pulse during a transfer makes the beat currently on offer the final one: that beat shows beat_last, and done follows its acceptance. A stop while idle has no effect.
- R10: A start pulse during a transfer is ignored. The addresses and the beat count of the running transfer are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (sampled only while idle) |
| int_base | input | AW | Internal start address |
| ext_base | input | AW | External start address |
| length | input | LW | Transfer length in bytes |
| stride | input | 12 | External address increment in bytes |
| xsize | input | 2 | Beat size code |
| stop | input | 1 | End the transfer at the next beat boundary |
| beat_ready | input | 1 | Consumer accepts the offered beat |
| beat_valid | output | 1 | A beat is offered |
| beat_int_addr | output | AW | Internal address of the offered beat |
| beat_ext_addr | output | AW | External address of the offered beat |
| beat_last | output | 1 | Offered beat is the final one |
| done | output | 1 | One-cycle completion pulse |
| bad_param | output | 1 | One-cycle parameter error pulse |

## Verification
The bench builds the block with AW = 16 and LW = 8. The narrow address width lets the external base sit close to the top of the address space, so strided runs wrap around zero within a few beats. The short length keeps a sweep over every size code, several strides and zero, one-beat and multi-beat lengths cheap enough to run completely. For each size code the bench also misaligns each of the four checked fields in turn. Separate cases place a stop and a repeated start at chosen beats while the ready pattern applies back-pressure.

// File: rtl/agen_pkg.sv
package agen_pkg;

    localparam int STRIDE_W = 12;

    typedef enum logic [1:0] {
        XS_BYTE  = 2'b00,
        XS_HALF  = 2'b01,
        XS_WORD  = 2'b10,
        XS_DWORD = 2'b11
    } xsize_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } agen_state_t;

    typedef struct packed {
        logic stride_mis;
        logic int_mis;
        logic ext_mis;
        logic len_mis;
    } param_fault_t;

    function automatic logic [2:0] xs_mask(input xsize_t xs);
        case (xs)
            XS_BYTE:  return 3'b000;
            XS_HALF:  return 3'b001;
            XS_WORD:  return 3'b011;
            default:  return 3'b111;
        endcase
    endfunction

    function automatic logic [3:0] xs_bytes(input xsize_t xs);
        return 4'(1) << xs;
    endfunction

    function automatic logic misaligned(input logic [2:0] lsbs, input xsize_t xs);
        return |(lsbs & xs_mask(xs));
    endfunction

endpackage

// File: rtl/agen_param_check.sv
module agen_param_check
    import agen_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic [AW-1:0]       int_base,
    input  logic [AW-1:0]       ext_base,
    input  logic [LW-1:0]       length,
    input  logic [STRIDE_W-1:0] stride,
    input  xsize_t              xsize,
    output logic                bad,
    output logic                zero_len,
    output logic [LW-1:0]       beats
);
    param_fault_t fault;

    always_comb begin
        fault.stride_mis = misaligned(stride[2:0], xsize);
        fault.int_mis    = misaligned(int_base[2:0], xsize);
        fault.ext_mis    = misaligned(ext_base[2:0], xsize);
        fault.len_mis    = misaligned(length[2:0], xsize);
    end

    assign bad      = |fault;
    assign beats    = length >> xsize;
    assign zero_len = (beats == '0);
endmodule

// File: rtl/agen_beat_ctr.sv
module agen_beat_ctr #(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [LW-1:0] load_val,
    input  logic          dec,
    output logic          is_one
);
    logic [LW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (dec && remain_q != '0) begin
            remain_q <= remain_q - LW'(1);
        end
    end

    assign is_one = (remain_q == LW'(1));
endmodule

// File: rtl/agen_addr_step.sv
module agen_addr_step #(
    parameter int AW = 32,
    parameter int SW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic [SW-1:0] step,
    input  logic          adv,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_q;
    logic [SW-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            step_q <= '0;
        end else if (load) begin
            addr_q <= base;
            step_q <= step;
        end else if (adv) begin
            addr_q <= addr_q + AW'(step_q);
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/strided_dma_agen.sv
module strided_dma_agen
    import agen_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [AW-1:0]       int_base,
    input  logic [AW-1:0]       ext_base,
    input  logic [LW-1:0]       length,
    input  logic [STRIDE_W-1:0] stride,
    input  logic [1:0]          xsize,
    input  logic                stop,
    input  logic                beat_ready,
    output logic                beat_valid,
    output logic [AW-1:0]       beat_int_addr,
    output logic [AW-1:0]       beat_ext_addr,
    output logic                beat_last,
    output logic                done,
    output logic                bad_param
);
    agen_state_t         state_q;
    xsize_t              xs_q;
    logic [STRIDE_W-1:0] stride_q;
    logic                stop_pend_q;
    logic                done_q;
    logic                bad_q;

    logic                chk_bad;
    logic                chk_zero;
    logic [LW-1:0]       chk_beats;
    logic                accept;
    logic                go;
    logic                hs;
    logic                final_beat;
    logic                end_now;
    logic                is_one;
    logic [STRIDE_W-1:0] int_step;

    agen_param_check #(.AW(AW), .LW(LW)) u_check (
        .int_base (int_base),
        .ext_base (ext_base),
        .length   (length),
        .stride   (stride),
        .xsize    (xsize_t'(xsize)),
        .bad      (chk_bad),
        .zero_len (chk_zero),
        .beats    (chk_beats)
    );

    assign accept     = start && (state_q == ST_IDLE);
    assign go         = accept && !chk_bad && !chk_zero;
    assign beat_valid = (state_q == ST_RUN);
    assign hs         = beat_valid && beat_ready;
    assign final_beat = is_one || stop || stop_pend_q;
    assign end_now    = hs && final_beat;
    assign beat_last  = beat_valid && final_beat;
    assign int_step   = STRIDE_W'(xs_bytes(xsize_t'(xsize)));

    agen_beat_ctr #(.LW(LW)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (go),
        .load_val (chk_beats),
        .dec      (hs),
        .is_one   (is_one)
    );

    agen_addr_step #(.AW(AW), .SW(STRIDE_W)) u_int (
        .clk  (clk),
        .rst  (rst),
        .load (go),
        .base (int_base),
        .step (int_step),
        .adv  (hs),
        .addr (beat_int_addr)
    );

    agen_addr_step #(.AW(AW), .SW(STRIDE_W)) u_ext (
        .clk  (clk),
        .rst  (rst),
        .load (go),
        .base (ext_base),
        .step (stride),
        .adv  (hs),
        .addr (beat_ext_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            xs_q        <= XS_BYTE;
            stride_q    <= '0;
            stop_pend_q <= 1'b0;
            done_q      <= 1'b0;
            bad_q       <= 1'b0;
        end else begin
            done_q <= (accept && !chk_bad && chk_zero) || end_now;
            bad_q  <= accept && chk_bad;
            case (state_q)
                ST_IDLE: begin
                    stop_pend_q <= 1'b0;
                    if (go) begin
                        state_q  <= ST_RUN;
                        xs_q     <= xsize_t'(xsize);
                        stride_q <= stride;
                    end
                end
                default: begin
                    if (end_now) begin
                        state_q     <= ST_IDLE;
                        stop_pend_q <= 1'b0;
                    end else if (stop) begin
                        stop_pend_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign done      = done_q;
    assign bad_param = bad_q;
endmodule

// File: rtl/strided_dma_agen_sva.sv
module strided_dma_agen_sva
    import agen_pkg::*;
#(
    parameter int AW = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                beat_valid,
    input logic                beat_ready,
    input logic                beat_last,
    input logic [AW-1:0]       beat_int_addr,
    input logic [AW-1:0]       beat_ext_addr,
    input logic                done,
    input logic                bad_param,
    input xsize_t              xs_q,
    input logic [STRIDE_W-1:0] stride_q
);
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_int_addr) && $stable(beat_ext_addr)));

    p_int_step_r2: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_ready && !beat_last) |=>
        (beat_int_addr == $past(beat_int_addr) + AW'(xs_bytes(xs_q))));

    p_ext_step_r3: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_ready && !beat_last) |=>
        (beat_ext_addr == $past(beat_ext_addr) + AW'(stride_q)));

    p_done_after_last_r8: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_ready && beat_last) |=> (done && !beat_valid));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_bad_no_beat_r5: assert property (@(posedge clk) disable iff (rst)
        bad_param |-> (!beat_valid && !done));

    p_bad_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        bad_param |=> !bad_param);

    p_last_valid_r8: assert property (@(posedge clk) disable iff (rst)
        beat_last |-> beat_valid);
endmodule

bind strided_dma_agen strided_dma_agen_sva #(.AW(AW)) u_sva (
    .clk           (clk),
    .rst           (rst),
    .beat_valid    (beat_valid),
    .beat_ready    (beat_ready),
    .beat_last     (beat_last),
    .beat_int_addr (beat_int_addr),
    .beat_ext_addr (beat_ext_addr),
    .done          (done),
    .bad_param     (bad_param),
    .xs_q          (xs_q),
    .stride_q      (stride_q)
);

// File: tb/tb_strided_dma_agen.sv
`timescale 1ns/100ps
module tb_strided_dma_agen;
    localparam int AW = 16;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] int_base = '0;
    logic [AW-1:0] ext_base = '0;
    logic [LW-1:0] length = '0;
    logic [11:0]   stride = '0;
    logic [1:0]    xsize = '0;
    logic          stop = 1'b0;
    logic          beat_ready = 1'b0;
    logic          beat_valid;
    logic [AW-1:0] beat_int_addr;
    logic [AW-1:0] beat_ext_addr;
    logic          beat_last;
    logic          done;
    logic          bad_param;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    strided_dma_agen #(.AW(AW), .LW(LW)) dut (
        .clk(clk), .rst(rst), .start(start), .int_base(int_base),
        .ext_base(ext_base), .length(length), .stride(stride), .xsize(xsize),
        .stop(stop), .beat_ready(beat_ready), .beat_valid(beat_valid),
        .beat_int_addr(beat_int_addr), .beat_ext_addr(beat_ext_addr),
        .beat_last(beat_last), .done(done), .bad_param(bad_param)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // stop_at < 0: no stop; restart_at < 0: no mid-transfer start
    task automatic run_xfer(input logic [AW-1:0] ib, input logic [AW-1:0] eb,
                            input int len, input int st, input int xs,
                            input int stop_at, input int restart_at);
        int sz, n, neff, k, guard;
        bit exp_bad, stopped;
        logic [AW-1:0] ei, ee;
        sz = 1 << xs;
        exp_bad = ((st % sz) != 0) || ((int'(ib) % sz) != 0) ||
                  ((int'(eb) % sz) != 0) || ((len % sz) != 0);
        n = len / sz;
        neff = (stop_at >= 0 && stop_at < n) ? stop_at + 1 : n;
        @(negedge clk);
        int_base = ib; ext_base = eb; length = LW'(len);
        stride = 12'(st); xsize = 2'(xs); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #0.5;
        if (exp_bad) begin
            check("R5 bad_param/valid", {bad_param, beat_valid}, 2'b10);
            @(negedge clk);
            check("R5 single pulse, no beat", {bad_param, beat_valid, done}, 3'b000);
            return;
        end
        check("R5 no error on good set", bad_param, 1'b0);
        if (n == 0) begin
            check("R6 zero length done", {done, beat_valid}, 2'b10);
            @(negedge clk);
            check("R6 no beat after zero length", {done, beat_valid}, 2'b00);
            return;
        end
        k = 0; guard = 0; stopped = 0;
        while (k < neff && guard < 2000) begin
            guard++;
            if (!stopped && stop_at == k) begin
                stop = 1'b1; beat_ready = 1'b0; stopped = 1;
            end else begin
                beat_ready = (((cyc * 5) + k + 3) % 4) != 0;
            end
            if (restart_at == k) begin
                start = 1'b1; int_base = 16'h0003; ext_base = 16'h0001;
                length = 8'd2; stride = 12'd1; xsize = 2'd0;
            end
            #0.5;
            ei = ib + AW'(k * sz);
            ee = eb + AW'(k * st);
            check("R7 valid held during transfer", beat_valid, 1'b1);
            check(st == 0 ? "R4 fixed ext addr" : "R3 ext addr", beat_ext_addr, ee);
            check("R2 int addr", beat_int_addr, ei);
            check(stop_at >= 0 ? "R9 last on stop" : "R8 last flag", beat_last, (k == neff - 1));
            if (restart_at == k)
                check("R10 no error from ignored start", bad_param, 1'b0);
            @(posedge clk);
            if (beat_ready) k++;
            @(negedge clk);
            stop = 1'b0; start = 1'b0; beat_ready = 1'b0;
        end
        #0.5;
        check("R8 done after final beat", {done, beat_valid}, 2'b10);
        @(negedge clk);
        #0.5;
        check("R8 done one cycle", {done, beat_valid}, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #0.5;
        check("R1 reset outputs", {beat_valid, beat_last, done, bad_param}, 4'b0000);
        rst = 1'b0;
        @(negedge clk);
        #0.5;
        check("R1 idle after reset", {beat_valid, beat_last, done, bad_param}, 4'b0000);

        // main sweep over size, stride and length
        for (int xs = 0; xs < 4; xs++) begin
            for (int si = 0; si < 4; si++) begin
                for (int li = 0; li < 3; li++) begin
                    int sz, st, len;
                    sz = 1 << xs;
                    st = (si == 0) ? 0 : (si == 1) ? sz : (si == 2) ? 3 * sz : (4095 & ~(sz - 1));
                    len = (li == 0) ? 0 : (li == 1) ? sz : 5 * sz;
                    if (len < 256)
                        run_xfer(16'h0100 + AW'(xs * 64), 16'hFFF0, len, st, xs, -1, -1);
                end
            end
        end

        // misalign each field in turn
        for (int xs = 1; xs < 4; xs++) begin
            int sz;
            sz = 1 << xs;
            run_xfer(16'h0200, 16'h0400, 4 * sz, sz + 1, xs, -1, -1);
            run_xfer(16'h0201, 16'h0400, 4 * sz, sz, xs, -1, -1);
            run_xfer(16'h0200, 16'h0401, 4 * sz, sz, xs, -1, -1);
            run_xfer(16'h0200, 16'h0400, 4 * sz + 1, sz, xs, -1, -1);
            run_xfer(16'h0200, 16'h0400, 2 * sz, sz, xs, -1, -1);
        end

        // stop handling and ignored start
        run_xfer(16'h0300, 16'h0800, 8 * 4, 12, 2, 3, -1);
        run_xfer(16'h0300, 16'h0800, 6, 1, 0, 0, -1);
        run_xfer(16'h0300, 16'h0800, 6 * 2, 0, 1, -1, 1);
        run_xfer(16'h0000, 16'h0008, 4 * 8, 40, 3, 2, 1);

        // stop while idle
        @(negedge clk);
        stop = 1'b1;
        repeat (3) begin
            @(negedge clk);
            #0.5;
            check("R9 stop while idle", {beat_valid, done, bad_param}, 3'b000);
        end
        stop = 1'b0;
        run_xfer(16'h0040, 16'h0080, 3, 2, 0, -1, -1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule